// File: doc/BRIEF.md
# Row-Parallel Block SAD Accumulator

This block measures how far a candidate reference block is from a current block. It reports the sum of absolute pixel differences over a 64 by 64 area. A caller sends the block one row at a time, and each row carries all 64 reference pixels and all 64 current pixels together. Each pixel lane forms the absolute difference of its two pixels. A balanced pairwise adder tree reduces the 64 lane results to one row sum, and a running accumulator adds the row sums into the block total. The caller pulses a start input to open a block. The block then takes up to one row per clock cycle. A one-cycle done pulse marks the moment the total is final.

A three-state controller sequences the work:
- IDLE waits for a start.
- COLLECT counts accepted rows.
- DRAIN waits for the last row to leave the pipeline.

The controller has four transitions:
- IDLE→COLLECT on start.
- COLLECT→COLLECT on start, which is a restart.
- COLLECT→DRAIN when the 64th row is accepted.
- DRAIN→IDLE when that row's sum is added to the total.

A start pulse during DRAIN is ignored. Fetching pixels and choosing candidates are left to the caller.

Top module: `sad_row_accum`

## Requirements
- R1: After reset, `blk_done` is low and `blk_sad` is zero.
- R2: Lane i occupies bits [8i+7:8i] of both `ref_row` and `src_row`. Lane i of `ref_row` is paired only with lane i of `src_row`. The final `blk_sad` equals the sum, over the 64 accepted rows and the 64 lanes, of |ref − src| for 8-bit unsigned pixels.
- R3: The difference is absolute: a lane gives the same contribution whether its reference pixel is above or below its source pixel.
- R4: The 20-bit total does not wrap. The worst case of 64×64×255 = 1044480 is reported exactly, and the total never decreases within a block.
- R5: A `blk_start` pulse clears the total to zero on the next cycle. Rows are accepted only in COLLECT and not in the cycle of `blk_start` itself.
- R6: `row_vld` has no effect in IDLE or DRAIN. The total stays the same and no done pulse appears.
- R7: In COLLECT a row is accepted in every cycle where `row_vld` is high. Idle cycles between rows do not change the result.
- R8: `blk_done` is high for exactly one cycle. It rises in the third cycle after the cycle in which the 64th row was accepted, and it is low in the two cycles before that.
- R9: After done, `blk_sad` holds its value until the next `blk_start`.
- R10: A `blk_start` in COLLECT restarts the block. It discards rows already in flight, and the result covers only rows accepted after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start | input | 1 | Opens a new block and clears the total |
| row_vld | input | 1 | Row pair on `ref_row`/`src_row` is valid |
| ref_row | input | 512 | 64 reference pixels, lane i in bits [8i+7:8i] |
| src_row | input | 512 | 64 current pixels, lane i in bits [8i+7:8i] |
| blk_sad | output | 20 | Running and final block SAD |
| blk_done | output | 1 | One-cycle pulse when `blk_sad` is final |

## Verification
The bench targets the following corner cases:
- **All-maximum block, in both polarities.** A tree or accumulator that is too narrow wraps. A subtraction that is not absolute wraps or gives a negative result in one of the two polarities.
- **Lane-indexed pattern.** A design that pairs lanes wrongly or misplaces bit fields gives a different total.
- **Bubbles between rows, and rows driven during DRAIN and IDLE.** A design that counts invalid cycles or accepts rows outside COLLECT gives a wrong total or an extra done pulse.
- **Done timing, sampled at offsets 0 to 3 after the last row.** An off-by-one in the pipeline shows up as a done pulse in the wrong cycle.
- **Restart in the middle of a block.** A design that does not flush in-flight rows adds stale rows to the new total.

// File: rtl/sad_pkg.sv
package sad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DRAIN   = 2'd2
    } sad_state_t;

endpackage

// File: rtl/sad_absdiff_stage.sv
module sad_absdiff_stage #(
    parameter int LANES = 64,
    parameter int PIX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   in_vld,
    input  logic                   in_last,
    input  logic [LANES*PIX_W-1:0] ref_row,
    input  logic [LANES*PIX_W-1:0] src_row,
    output logic                   d_vld,
    output logic                   d_last,
    output logic [LANES*PIX_W-1:0] d_flat
);

    logic [LANES*PIX_W-1:0] diff_c;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        assign a = ref_row[i*PIX_W +: PIX_W];
        assign b = src_row[i*PIX_W +: PIX_W];
        assign diff_c[i*PIX_W +: PIX_W] = (a >= b) ? (a - b) : (b - a);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_vld  <= 1'b0;
            d_last <= 1'b0;
            d_flat <= '0;
        end else begin
            d_vld  <= in_vld && !flush;
            d_last <= in_last && !flush;
            if (in_vld) begin
                d_flat <= diff_c;
            end
        end
    end

endmodule

// File: rtl/sad_tree_stage.sv
module sad_tree_stage #(
    parameter int LANES = 64,
    parameter int PIX_W = 8,
    parameter int SUM_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   d_vld,
    input  logic                   d_last,
    input  logic [LANES*PIX_W-1:0] d_flat,
    output logic                   s_vld,
    output logic                   s_last,
    output logic [SUM_W-1:0]       s_sum
);

    localparam int LEVELS = $clog2(LANES);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N = LANES >> l;
        logic [SUM_W-1:0] v [N];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_in
                assign v[i] = SUM_W'(d_flat[i*PIX_W +: PIX_W]);
            end
        end else begin : g_node
            for (genvar i = 0; i < N; i++) begin : g_add
                assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_vld  <= 1'b0;
            s_last <= 1'b0;
            s_sum  <= '0;
        end else begin
            s_vld  <= d_vld && !flush;
            s_last <= d_last && !flush;
            if (d_vld) begin
                s_sum <= g_lvl[LEVELS].v[0];
            end
        end
    end

endmodule

// File: rtl/sad_ctrl_fsm.sv
module sad_ctrl_fsm
    import sad_pkg::*;
#(
    parameter int ROWS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_start,
    input  logic       row_vld,
    input  logic       retire_last,
    output sad_state_t cur_state,
    output logic       accept,
    output logic       accept_last,
    output logic       flush
);

    localparam int CNT_W = $clog2(ROWS);

    sad_state_t       state_q;
    sad_state_t       state_d;
    logic [CNT_W-1:0] row_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (blk_start) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (blk_start) begin
                    state_d = ST_COLLECT;
                end else if (accept_last) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN:   if (retire_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept      = 1'b0;
        accept_last = 1'b0;
        flush       = 1'b0;
        unique case (state_q)
            ST_IDLE:    flush = blk_start;
            ST_COLLECT: begin
                flush       = blk_start;
                accept      = row_vld && !blk_start;
                accept_last = accept && (row_cnt == CNT_W'(ROWS - 1));
            end
            ST_DRAIN:   flush = 1'b0;
            default:    flush = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_cnt <= '0;
        end else if (flush) begin
            row_cnt <= '0;
        end else if (accept) begin
            row_cnt <= row_cnt + 1'b1;
        end
    end

    assign cur_state = state_q;

endmodule

// File: rtl/sad_row_accum.sv
module sad_row_accum
    import sad_pkg::*;
#(
    parameter int LANES = 64,
    parameter int PIX_W = 8,
    parameter int ROWS  = 64,
    localparam int PIX_MAX = (1 << PIX_W) - 1,
    localparam int SUM_W   = $clog2(LANES * PIX_MAX + 1),
    localparam int ACC_W   = $clog2(ROWS * LANES * PIX_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_start,
    input  logic                   row_vld,
    input  logic [LANES*PIX_W-1:0] ref_row,
    input  logic [LANES*PIX_W-1:0] src_row,
    output logic [ACC_W-1:0]       blk_sad,
    output logic                   blk_done
);

    sad_state_t             cur_state;
    logic                   accept;
    logic                   accept_last;
    logic                   flush;
    logic                   d_vld;
    logic                   d_last;
    logic [LANES*PIX_W-1:0] d_flat;
    logic                   s_vld;
    logic                   s_last;
    logic [SUM_W-1:0]       s_sum;
    logic [ACC_W-1:0]       acc_q;
    logic                   done_q;

    sad_ctrl_fsm #(.ROWS(ROWS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_start   (blk_start),
        .row_vld     (row_vld),
        .retire_last (s_vld && s_last),
        .cur_state   (cur_state),
        .accept      (accept),
        .accept_last (accept_last),
        .flush       (flush)
    );

    sad_absdiff_stage #(.LANES(LANES), .PIX_W(PIX_W)) u_diff (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .in_vld  (accept),
        .in_last (accept_last),
        .ref_row (ref_row),
        .src_row (src_row),
        .d_vld   (d_vld),
        .d_last  (d_last),
        .d_flat  (d_flat)
    );

    sad_tree_stage #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .d_vld  (d_vld),
        .d_last (d_last),
        .d_flat (d_flat),
        .s_vld  (s_vld),
        .s_last (s_last),
        .s_sum  (s_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= s_vld && s_last && !flush;
            if (flush) begin
                acc_q <= '0;
            end else if (s_vld) begin
                acc_q <= acc_q + ACC_W'(s_sum);
            end
        end
    end

    assign blk_sad  = acc_q;
    assign blk_done = done_q;

endmodule

// File: rtl/sad_row_accum_chk.sv
module sad_row_accum_chk
    import sad_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_start,
    input logic [ACC_W-1:0] blk_sad,
    input logic             blk_done,
    input sad_state_t       state
);

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R8
    done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> ($past(state) == ST_DRAIN));

    // R5
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && state != ST_DRAIN) |=> (blk_sad == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start |=> (blk_sad >= $past(blk_sad)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !blk_start) |=> $stable(blk_sad));

    // R10
    restart_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && state == ST_COLLECT) |=> (state == ST_COLLECT));

endmodule

bind sad_row_accum sad_row_accum_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .blk_sad   (blk_sad),
    .blk_done  (blk_done),
    .state     (cur_state)
);

// File: tb/sad_row_accum_tb.sv
module sad_row_accum_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    // fields: {ref a, ref b, ref c, src a, src b, src c, bubble}
    // pixel(r,i) = (a*r + b*i + c) mod 256
    localparam logic [55:0] VEC [NVEC] = '{
        {8'd0,  8'd0, 8'd0,   8'd0, 8'd0,  8'd0,   8'd0},
        {8'd0,  8'd0, 8'd255, 8'd0, 8'd0,  8'd0,   8'd0},
        {8'd0,  8'd0, 8'd0,   8'd0, 8'd0,  8'd255, 8'd0},
        {8'd3,  8'd5, 8'd17,  8'd3, 8'd5,  8'd17,  8'd0},
        {8'd1,  8'd7, 8'd0,   8'd2, 8'd3,  8'd9,   8'd0},
        {8'd11, 8'd1, 8'd200, 8'd5, 8'd13, 8'd40,  8'd3},
        {8'd0,  8'd1, 8'd0,   8'd0, 8'd0,  8'd0,   8'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_start = 1'b0;
    logic         row_vld = 1'b0;
    logic [511:0] ref_row = '0;
    logic [511:0] src_row = '0;
    logic [19:0]  blk_sad;
    logic         blk_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sad_row_accum u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .row_vld   (row_vld),
        .ref_row   (ref_row),
        .src_row   (src_row),
        .blk_sad   (blk_sad),
        .blk_done  (blk_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] pix(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] c, input int r, input int i);
        int t;
        t = int'(a) * r + int'(b) * i + int'(c);
        return 8'(t);
    endfunction

    function automatic logic [511:0] mk_row(input logic [7:0] a, input logic [7:0] b,
                                            input logic [7:0] c, input int r);
        logic [511:0] v;
        for (int i = 0; i < 64; i++) v[i*8 +: 8] = pix(a, b, c, r, i);
        return v;
    endfunction

    function automatic int exp_sad(input logic [55:0] w);
        int s = 0;
        for (int r = 0; r < 64; r++) begin
            for (int i = 0; i < 64; i++) begin
                int x;
                int y;
                x = int'(pix(w[55:48], w[47:40], w[39:32], r, i));
                y = int'(pix(w[31:24], w[23:16], w[15:8], r, i));
                s += (x > y) ? (x - y) : (y - x);
            end
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Opens a block, feeds 64 rows and checks done timing and total.
    // tail=1 keeps row_vld high with junk rows through DRAIN and into IDLE.
    task automatic run_block(input logic [55:0] w, input bit tail, input string req);
        int expv;
        int bub;
        expv = exp_sad(w);
        bub = int'(w[7:0]);
        @(negedge clk);
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        for (int r = 0; r < 64; r++) begin
            ref_row = mk_row(w[55:48], w[47:40], w[39:32], r);
            src_row = mk_row(w[31:24], w[23:16], w[15:8], r);
            row_vld = 1'b1;
            @(negedge clk);
            if (bub > 0 && (r % bub) == bub - 1 && r != 63) begin
                row_vld = 1'b0;
                ref_row = '1;
                @(negedge clk);
            end
        end
        if (tail) begin
            ref_row = '1;
            src_row = '0;
        end else begin
            row_vld = 1'b0;
        end
        // R8 done low at offsets 0 and 1, high at 2, low at 3
        chk(blk_done == 1'b0, "R8 done early", blk_done, 0);
        @(negedge clk);
        chk(blk_done == 1'b0, "R8 done early", blk_done, 0);
        @(negedge clk);
        chk(blk_done == 1'b1, "R8 done missing", blk_done, 1);
        chk(blk_sad == 20'(expv), req, blk_sad, expv);
        @(negedge clk);
        row_vld = 1'b0;
        chk(blk_done == 1'b0, "R8 done longer than one cycle", blk_done, 0);
        // R9 total held after done
        chk(blk_sad == 20'(expv), "R9 hold after done", blk_sad, expv);
    endtask

    initial begin
        // R1 reset state
        #(CLK_PERIOD * 2 + 1);
        chk(blk_done == 1'b0, "R1 reset done", blk_done, 0);
        chk(blk_sad == '0, "R1 reset sad", blk_sad, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(blk_sad == '0, "R1 sad after reset release", blk_sad, 0);

        // table walk: R2 lanes and totals, R3 polarity, R4 maximum, R7 bubbles
        for (int k = 0; k < NVEC; k++) begin
            run_block(VEC[k], 1'b0, (k == 1 || k == 2) ? "R4 R3 max total" :
                      (k == 5) ? "R7 total with bubbles" : "R2 block total");
        end

        // R6 rows in IDLE ignored
        begin
            int held;
            held = int'(blk_sad);
            ref_row = '1;
            src_row = '0;
            row_vld = 1'b1;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                chk(blk_done == 1'b0, "R6 no done from IDLE rows", blk_done, 0);
            end
            row_vld = 1'b0;
            @(negedge clk);
            @(negedge clk);
            @(negedge clk);
            chk(int'(blk_sad) == held, "R6 IDLE rows ignored", blk_sad, held);
            chk(blk_done == 1'b0, "R6 no done from IDLE rows", blk_done, 0);
        end

        // R6 rows during DRAIN ignored (tail)
        run_block(VEC[4], 1'b1, "R6 DRAIN rows ignored");

        // R5 start clears total
        @(negedge clk);
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        chk(blk_sad == '0, "R5 start clears", blk_sad, 0);
        @(negedge clk);

        // R10 restart mid-block: feed 10 max rows, then restart with row_vld held
        ref_row = '1;
        src_row = '0;
        row_vld = 1'b1;
        for (int c = 0; c < 10; c++) @(negedge clk);
        run_block(VEC[6], 1'b0, "R10 restart discards old rows");

        // R2 back-to-back with R5: start right after previous done
        run_block(VEC[3], 1'b0, "R5 fresh block after prior total");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule